// File: doc/BRIEF.md
# DRAM Command Sequence Generator

This block turns one memory request (bank, row and a read/write flag) into the ordered list of DRAM commands that serves it. It keeps a small table that records, for each bank, whether a row is open and which one. It uses that table to pick one of three cases. A request whose row is already open needs only the data command. A request whose bank holds some other row must first close that row, then open the new one, then transfer. A request to a bank with nothing open must open the row and then transfer.

Commands leave one per valid/ready handshake on an output stream. Each command carries an opcode, the bank, the row and a flag that marks the final command of the sequence. The table is updated when an open or close command is handed off. A refresh controller can clear the whole table with a one-cycle close-all pulse. Command timing, address mapping and data movement belong to other blocks.

The controller is a four-state machine. IDLE waits for a request and classifies it on acceptance. The classification moves it to XFER (row hit), PRE (row miss) or ACT (bank idle). Each state advances on a handshake: PRE goes to ACT, ACT goes to XFER, and XFER returns to IDLE.

Top module: `dram_cmd_seq_gen`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0 and every bank is idle, so the first request to any bank produces an activate followed by the data command.
- R2: A request whose bank holds the requested row open produces exactly one command, the data command, with cmd_last set.
- R3: A request whose bank holds a different row produces three commands in the order precharge, activate, data command, with cmd_last set only on the third.
- R4: A request to a bank with no open row produces two commands, activate then data command, with cmd_last set only on the second.
- R5: Opcodes are encoded as precharge 0, activate 1, read 2 and write 3. The data command is 2 for a read request (req_write=0) and 3 for a write request (req_write=1). Every command of a sequence carries the request's bank and row.
- R6: Handing off an activate records the request's row as open in that bank. Handing off a precharge marks that bank idle.
- R7: A close_all pulse marks every bank idle. It wins over an activate handed off in the same cycle, and a request accepted in the same cycle is classified as if its bank were idle.
- R8: req_ready is 1 exactly when no sequence is in flight. The next request can be accepted in the cycle after the handshake of a command with cmd_last set, and an accepted request presents its first command in the next cycle.
- R9: While cmd_valid is 1 and cmd_ready is 0, the command outputs hold their values in the next cycle.
- R10: Banks are independent: opening or closing a row in one bank does not change the classification of requests to any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block can accept a request |
| req_bank | input | 3 | Target bank of the request |
| req_row | input | 14 | Target row of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| close_all | input | 1 | Refresh pulse that marks every bank idle |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | Downstream takes the command |
| cmd_op | output | 2 | Opcode: 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank | output | 3 | Bank of the command |
| cmd_row | output | 14 | Row of the command |
| cmd_last | output | 1 | Final command of the sequence |

## Verification
The assertions assume that req_bank, req_row and req_write are steady in the cycle where req_valid meets req_ready. They also assume that cmd_ready may drop at any time, and that close_all is a level that is sampled every cycle. The bench changes request fields only while nothing is being accepted. It drops cmd_ready at random inside sequences. It places close_all on acceptance cycles, on activate handoffs and on idle cycles, so that every case where the clear has priority is reached. Rows are drawn from a small set over a few banks, so that hits, misses and idle banks all occur often.

// File: rtl/dcsg_pkg.sv
package dcsg_pkg;

    typedef enum logic [1:0] {
        OP_PRE = 2'd0,
        OP_ACT = 2'd1,
        OP_RD  = 2'd2,
        OP_WR  = 2'd3
    } dram_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_XFER
    } seq_state_e;

endpackage

// File: rtl/dcsg_row_table.sv
module dcsg_row_table #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              drop_en,
    input  logic [BANK_W-1:0] drop_bank,
    input  logic [BANK_W-1:0] look_bank,
    output logic              look_valid,
    output logic [ROW_W-1:0]  look_row
);

    logic                 open_q [NUM_BANKS];
    logic [ROW_W-1:0]     row_q  [NUM_BANKS];
    logic [NUM_BANKS-1:0] open_vec;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (clear_all) begin
                open_q[b] <= 1'b0;
            end else if (set_en && (set_bank == BANK_W'(b))) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= set_row;
            end else if (drop_en && (drop_bank == BANK_W'(b))) begin
                open_q[b] <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            open_vec[i] = open_q[i];
        end
    end

    assign look_valid = open_q[look_bank];
    assign look_row   = row_q[look_bank];

    // R7: a clear leaves no bank open, whatever else happened that cycle
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (open_vec == '0));

    // R6: an activate handoff records the row
    a_r6_act_records: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clear_all) |=> (open_q[$past(set_bank)] && (row_q[$past(set_bank)] == $past(set_row))));

    // R6: a precharge handoff closes the bank
    a_r6_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_en && !set_en) |=> !open_q[$past(drop_bank)]);

endmodule

// File: rtl/dcsg_seq_fsm.sv
module dcsg_seq_fsm
    import dcsg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              req_write,
    input  logic              bank_open,
    input  logic [ROW_W-1:0]  bank_row,
    input  logic              close_all,
    input  logic              cmd_ready,
    output logic              req_ready,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic              cmd_last,
    output logic              act_done,
    output logic              pre_done
);

    seq_state_e        state_q, state_d;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic              wr_q;
    logic              accept, fire, open_eff;
    seq_state_e        first_st;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign fire     = cmd_valid && cmd_ready;
    assign open_eff = bank_open && !close_all;

    always_comb begin
        if (!open_eff)                first_st = ST_ACT;
        else if (bank_row == req_row) first_st = ST_XFER;
        else                          first_st = ST_PRE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = first_st;
            ST_PRE:  if (fire)   state_d = ST_ACT;
            ST_ACT:  if (fire)   state_d = ST_XFER;
            ST_XFER: if (fire)   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
            row_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bank_q <= req_bank;
                row_q  <= req_row;
                wr_q   <= req_write;
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        cmd_valid = 1'b1;
        cmd_last  = 1'b0;
        cmd_op    = OP_PRE;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                cmd_valid = 1'b0;
            end
            ST_PRE:  cmd_op = OP_PRE;
            ST_ACT:  cmd_op = OP_ACT;
            ST_XFER: begin
                cmd_op   = wr_q ? OP_WR : OP_RD;
                cmd_last = 1'b1;
            end
        endcase
    end

    assign cmd_bank = bank_q;
    assign cmd_row  = row_q;
    assign act_done = fire && (state_q == ST_ACT);
    assign pre_done = fire && (state_q == ST_PRE);

    // R9: a stalled command is held
    a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bank)
                                       && $stable(cmd_row) && $stable(cmd_last)));

    // R8: the final handoff reopens the request side
    a_r8_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_last) |=> req_ready);

    // R8: an accepted request shows its first command next cycle
    a_r8_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_valid && !req_ready));

    // R5: only a data command closes a sequence
    a_r5_last_is_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_last) |-> (cmd_op == OP_RD || cmd_op == OP_WR));

    // R3: a precharge is always followed by an activate
    a_r3_pre_then_act: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_PRE) |=> (cmd_valid && cmd_op == OP_ACT));

endmodule

// File: rtl/dram_cmd_seq_gen.sv
module dram_cmd_seq_gen #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              req_write,
    input  logic              close_all,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic              cmd_last
);

    logic             look_valid;
    logic [ROW_W-1:0] look_row;
    logic             act_done, pre_done;

    dcsg_row_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (close_all),
        .set_en     (act_done),
        .set_bank   (cmd_bank),
        .set_row    (cmd_row),
        .drop_en    (pre_done),
        .drop_bank  (cmd_bank),
        .look_bank  (req_bank),
        .look_valid (look_valid),
        .look_row   (look_row)
    );

    dcsg_seq_fsm #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_write (req_write),
        .bank_open (look_valid),
        .bank_row  (look_row),
        .close_all (close_all),
        .cmd_ready (cmd_ready),
        .req_ready (req_ready),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .cmd_row   (cmd_row),
        .cmd_last  (cmd_last),
        .act_done  (act_done),
        .pre_done  (pre_done)
    );

endmodule

// File: tb/sim_dram_cmd_seq_gen.sv
module sim_dram_cmd_seq_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_bank = '0;
    logic [13:0] req_row = '0;
    logic        req_write = 1'b0;
    logic        close_all = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [1:0]  cmd_op;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic        cmd_last;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    int    m_open [8];
    int    m_row  [8];
    int    q_op[$], q_bank[$], q_row[$], q_last[$];
    string q_tag[$];
    string g_tag = "R1";
    bit    g_acc;

    always #5 clk = ~clk;

    dram_cmd_seq_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_write(req_write),
        .close_all(close_all), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_last(cmd_last)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input int op, input int last);
        q_op.push_back(op);
        q_bank.push_back(int'(req_bank));
        q_row.push_back(int'(req_row));
        q_last.push_back(last);
        q_tag.push_back(g_tag);
    endtask

    // compare, advance model across one rising edge, move to next falling edge
    task automatic cycle();
        bit exp_v;
        int data_op;
        exp_v = (q_op.size() != 0);
        g_acc = 1'b0;
        chk("R8", "cmd_valid", int'(cmd_valid), int'(exp_v));
        chk("R8", "req_ready", int'(req_ready), int'(!exp_v));
        if (exp_v && cmd_valid) begin
            chk(q_tag[0], "cmd_op",   int'(cmd_op),   q_op[0]);
            chk(q_tag[0], "cmd_bank", int'(cmd_bank), q_bank[0]);
            chk(q_tag[0], "cmd_row",  int'(cmd_row),  q_row[0]);
            chk(q_tag[0], "cmd_last", int'(cmd_last), q_last[0]);
        end
        if (req_valid && !exp_v) begin
            g_acc = 1'b1;
            data_op = req_write ? 3 : 2;
            if (m_open[req_bank] == 0 || close_all) begin
                push(1, 0); push(data_op, 1);
            end else if (m_row[req_bank] == int'(req_row)) begin
                push(data_op, 1);
            end else begin
                push(0, 0); push(1, 0); push(data_op, 1);
            end
        end
        if (exp_v && cmd_ready) begin
            if (q_op[0] == 1) begin m_open[q_bank[0]] = 1; m_row[q_bank[0]] = q_row[0]; end
            if (q_op[0] == 0) m_open[q_bank[0]] = 0;
            void'(q_op.pop_front()); void'(q_bank.pop_front()); void'(q_row.pop_front());
            void'(q_last.pop_front()); void'(q_tag.pop_front());
        end
        if (close_all) for (int i = 0; i < 8; i++) m_open[i] = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input int b, input int r, input bit w, input bit cl, input string tag);
        g_tag     = tag;
        req_bank  = 3'(b);
        req_row   = 14'(r);
        req_write = w;
        req_valid = 1'b1;
        close_all = cl;
        g_acc     = 1'b0;
        while (!g_acc) begin
            cycle();
            close_all = 1'b0;
        end
        req_valid = 1'b0;
    endtask

    task automatic drain(input bit rnd);
        while (q_op.size() != 0) begin
            cmd_ready = rnd ? ($urandom % 3 != 0) : 1'b1;
            close_all = rnd && ($urandom % 8 == 0);
            cycle();
        end
        cmd_ready = 1'b1;
        close_all = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_open[i] = 0; m_row[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "cmd_valid after reset", int'(cmd_valid), 0);
        chk("R1", "req_ready after reset", int'(req_ready), 1);
        send(0, 5, 1'b0, 1'b0, "R1"); drain(1'b0);   // R4 idle bank: ACT, RD
        send(0, 5, 1'b1, 1'b0, "R2"); drain(1'b0);   // R2 hit: WR only
        send(0, 9, 1'b0, 1'b0, "R3"); drain(1'b0);   // R3 miss: PRE ACT RD
        send(1, 9, 1'b1, 1'b0, "R4"); drain(1'b0);   // R4 other bank idle
        send(0, 9, 1'b0, 1'b0, "R10"); drain(1'b0);  // R10 bank 0 still open
        send(1, 9, 1'b0, 1'b0, "R10"); drain(1'b0);
        // R5: read and write opcodes on the same open row
        send(1, 9, 1'b1, 1'b0, "R5"); drain(1'b0);
        // R7: lone clear, then request sees an idle bank
        close_all = 1'b1; cycle(); close_all = 1'b0;
        send(0, 9, 1'b0, 1'b0, "R7"); drain(1'b0);
        // R7: clear in the acceptance cycle
        send(0, 9, 1'b1, 1'b1, "R7"); drain(1'b0);
        // R7: clear on the activate handoff wins
        send(2, 7, 1'b0, 1'b0, "R7");
        close_all = 1'b1; cycle(); close_all = 1'b0;
        drain(1'b0);
        send(2, 7, 1'b0, 1'b0, "R7"); drain(1'b0);
        // R6: precharge closes, activate records the new row
        send(2, 3, 1'b1, 1'b0, "R6"); drain(1'b0);
        send(2, 3, 1'b0, 1'b0, "R6"); drain(1'b0);
        // R9: stall on each command of a miss sequence
        send(2, 4, 1'b0, 1'b0, "R9");
        for (int k = 0; k < 3; k++) begin
            cmd_ready = 1'b0; cycle(); cycle();
            cmd_ready = 1'b1; cycle();
        end
        drain(1'b0);
        // mixed traffic with random stalls and clears
        for (int n = 0; n < 400; n++) begin
            send(int'($urandom % 4), int'($urandom % 3), 1'($urandom % 2),
                 ($urandom % 6 == 0), "R10");
            drain(1'b1);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule